// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

The block takes a stereo pair of received audio samples, each up to 28 bits wide and MSB-aligned, and shifts them out on one serial data line. It generates the bit clock and the word clock itself. A 3-bit layout code picks one of eight layouts: left-justified, I2S at two word widths, right-justified at three word widths, LSB-first, and a bi-phase coded line. The block runs from a clock at twice the bit rate. A frame is 128 of those clocks, which is 64 bit clocks, split into two slots of 32 bit clocks each.

A source selector decides what reaches the data line. It can pass the formatted received samples, the raw pass-through serial input, or a constant zero. The choice depends on the PLL lock input and on three control bits: a mute, a force-pass-through and an unlocked-mute option. Samples arrive with a frame strobe and are held until the frame boundary. The layout code and the source choice are also sampled only at the frame boundary, so each frame is sent entirely in one layout from one source.

Top module: `audio_serial_fmt`

## Requirements
- R1: After reset the first frame is silent (sdata 0), with word-clock timing of layout 000. Frame timing starts with the clock cycle in which reset is released.
- R2: bclk equals bit 0 of a free-running 7-bit cycle count, giving 64 bit clocks per 128-cycle frame. Bit cell p (0..31) of a slot covers cycles 2p and 2p+1. The left slot is the first 64 cycles. wclk is low in the left slot for layouts 001 and 110, and high in the left slot for all other layouts.
- R3: Layout 000 sends sample bits 27 down to 4, one bit per cell in cells 0..23, then zeros.
- R4: Layout 001 sends sample bits 27..4 in cells 1..24, and layout 110 sends bits 27..0 in cells 1..28. All other cells carry zero.
- R5: Layouts 010, 011 and 100 send the top 24, 20 or 16 sample bits MSB-first so that the last bit lands in cell 31, with leading zeros.
- R6: Layout 111 sends sample bits 0..27 LSB-first in cells 0..27, then zeros.
- R7: Layout 101 codes the layout-000 bit stream in bi-phase form. The line inverts at the start of every cell, and inverts again at the middle of a cell that carries a 1.
- R8: The source is chosen in priority order. Mute gives 0. Otherwise force-pass-through gives thru_in. Otherwise, with the PLL unlocked, the output is 0 if unlock_mute is 1 and thru_in if it is 0. Otherwise the formatted samples are sent. The thru_in input appears on sdata in the same cycle.
- R9: Samples are captured on frame_stb. The held samples, the layout code and the source are taken at the last cycle of a frame (count 127) and used for the whole next frame. If no strobe comes, the previous samples are sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Captures left_in/right_in |
| left_in | input | 28 | Left sample, MSB-aligned |
| right_in | input | 28 | Right sample, MSB-aligned |
| fmt_sel | input | 3 | Output layout code |
| pll_locked | input | 1 | PLL lock status |
| unlock_mute | input | 1 | 1: mute instead of pass-through when unlocked |
| force_thru | input | 1 | Force pass-through whatever the lock state |
| mute | input | 1 | Force output to zero |
| thru_in | input | 1 | Pass-through serial input |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock |
| sdata | output | 1 | Serial data output |

## Verification
The hardest state to reach from the ports is the bi-phase line level. It carries over from every earlier frame, including muted and pass-through frames and frames in other layouts. A bench that only checks bi-phase frames in isolation therefore cannot predict it. The bench keeps its own running model of the line level from reset onward. Random frames mix all eight layouts with mute, force and lock changes, and some frames skip the sample strobe. Directed frames first walk every layout code and every source-priority combination. Controls are changed at the start of each frame, so every check also shows that a change waits for the next boundary.

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_stb,
  input  logic [27:0] left_in,
  input  logic [27:0] right_in,
  input  logic [2:0]  fmt_sel,
  input  logic        pll_locked,
  input  logic        unlock_mute,
  input  logic        force_thru,
  input  logic        mute,
  input  logic        thru_in,
  output logic        bclk,
  output logic        wclk,
  output logic        sdata
);
  localparam logic [1:0] SRC_RX = 2'd0, SRC_THRU = 2'd1, SRC_MUTE = 2'd2;

  logic [6:0]  cnt;
  logic [27:0] hold_l, hold_r, act_l, act_r;
  logic [2:0]  act_fmt;
  logic [1:0]  act_src, src_next;
  logic        bp, valid, nrz;
  logic [4:0]  k;

  wire        frame_end = (cnt == 7'd127);
  wire [4:0]  pos       = cnt[5:1];
  wire [27:0] word      = cnt[6] ? act_r : act_l;
  wire        i2s       = (act_fmt == 3'b001) || (act_fmt == 3'b110);

  assign src_next = mute ? SRC_MUTE :
                    force_thru ? SRC_THRU :
                    !pll_locked ? (unlock_mute ? SRC_MUTE : SRC_THRU) : SRC_RX;

  always_comb begin
    valid = 1'b0;
    k     = pos;
    unique case (act_fmt)
      3'b000, 3'b101: valid = (pos < 5'd24);
      3'b001: begin valid = (pos >= 5'd1) && (pos <= 5'd24); k = pos - 5'd1; end
      3'b110: begin valid = (pos >= 5'd1) && (pos <= 5'd28); k = pos - 5'd1; end
      3'b010: begin valid = (pos >= 5'd8);  k = pos - 5'd8;  end
      3'b011: begin valid = (pos >= 5'd12); k = pos - 5'd12; end
      3'b100: begin valid = (pos >= 5'd16); k = pos - 5'd16; end
      3'b111: begin valid = (pos < 5'd28);  k = 5'd27 - pos; end
      default: valid = 1'b0;
    endcase
    nrz = valid && word[5'd27 - k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hold_l  <= '0;
      hold_r  <= '0;
      act_l   <= '0;
      act_r   <= '0;
      act_fmt <= 3'b000;
      act_src <= SRC_MUTE;
      bp      <= 1'b0;
    end else begin
      cnt <= cnt + 7'd1;
      if (frame_stb) begin
        hold_l <= left_in;
        hold_r <= right_in;
      end
      if (frame_end) begin
        act_l   <= hold_l;
        act_r   <= hold_r;
        act_fmt <= fmt_sel;
        act_src <= src_next;
      end
      if (cnt[0])
        bp <= ~bp;
      else if (act_fmt == 3'b101 && nrz)
        bp <= ~bp;
    end
  end

  assign bclk  = cnt[0];
  assign wclk  = i2s ? cnt[6] : ~cnt[6];
  assign sdata = (act_src == SRC_MUTE) ? 1'b0 :
                 (act_src == SRC_THRU) ? thru_in :
                 (act_fmt == 3'b101)   ? bp : nrz;

  // R2
  wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 7'd0 && cnt != 7'd64) |-> $stable(wclk));

  // R9
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 7'd0) |-> ($stable(act_fmt) && $stable(act_src)));

  // R8
  mute_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && mute) |=> (sdata == 1'b0));

  // R8
  force_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !mute && force_thru) |=> (sdata == thru_in));

  // R7
  biphase_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fmt == 3'b101 && act_src == SRC_RX && !cnt[0] && cnt != 7'd0)
      |-> (sdata != $past(sdata)));
endmodule

// File: tb/tb_audio_serial_fmt.sv
module tb_audio_serial_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 1'b0, pll_locked = 1'b0, unlock_mute = 1'b0;
  logic force_thru = 1'b0, mute = 1'b0, thru_in = 1'b0;
  logic [27:0] left_in = '0, right_in = '0;
  logic [2:0] fmt_sel = '0;
  logic bclk, wclk, sdata;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_serial_fmt dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .left_in(left_in),
    .right_in(right_in), .fmt_sel(fmt_sel), .pll_locked(pll_locked),
    .unlock_mute(unlock_mute), .force_thru(force_thru), .mute(mute),
    .thru_in(thru_in), .bclk(bclk), .wclk(wclk), .sdata(sdata));

  function automatic logic exp_nrz(input logic [2:0] f, input logic [27:0] w, input int p);
    case (f)
      3'd0, 3'd5: if (p < 24) return w[27 - p];
      3'd1: if (p >= 1 && p <= 24) return w[28 - p];
      3'd6: if (p >= 1 && p <= 28) return w[28 - p];
      3'd2: if (p >= 8) return w[35 - p];
      3'd3: if (p >= 12) return w[39 - p];
      3'd4: if (p >= 16) return w[43 - p];
      3'd7: if (p < 28) return w[p];
      default: return 1'b0;
    endcase
    return 1'b0;
  endfunction

  // 0 = received, 1 = pass-through, 2 = mute
  function automatic int exp_src(input logic m, input logic fo, input logic lk, input logic um);
    if (m) return 2;
    if (fo) return 1;
    if (!lk) return um ? 2 : 1;
    return 0;
  endfunction

  function automatic string fmt_tag(input logic [2:0] f);
    case (f)
      3'd0: return "R3";
      3'd1, 3'd6: return "R4";
      3'd2, 3'd3, 3'd4: return "R5";
      3'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input int f, input int c);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s frame %0d cycle %0d: got %b expected %b", tag, f, c, act, exp);
    end
  endtask

  initial begin
    logic [27:0] hl, hr, cl, cr;
    logic [2:0] cf, nf;
    int cs, ns;
    logic bp, slot, e;
    bit rep, nrep, stb_now;
    string tag;
    int unsigned seed;
    seed = $urandom(32'h1F2E3D);
    hl = '0; hr = '0; cl = '0; cr = '0; cf = 3'd0; nf = 3'd0;
    cs = 2; ns = 2; bp = 1'b0; rep = 0; nrep = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 64; f++) begin
      // choose the configuration used in frame f+1
      stb_now = (f < 12) || ($urandom % 5 != 0);
      mute = 0; force_thru = 0; unlock_mute = 0; pll_locked = 1;
      if (f < 8) nf = f[2:0];
      else if (f == 8) begin mute = 1; force_thru = 1; nf = 3'd0; end
      else if (f == 9) begin force_thru = 1; pll_locked = 0; nf = 3'd5; end
      else if (f == 10) begin pll_locked = 0; unlock_mute = 1; nf = 3'd1; end
      else if (f == 11) begin pll_locked = 0; nf = 3'd7; end
      else begin
        nf = 3'($urandom % 8);
        mute = ($urandom % 6 == 0);
        force_thru = ($urandom % 4 == 0);
        pll_locked = ($urandom % 3 != 0);
        unlock_mute = $urandom % 2;
      end
      fmt_sel = nf;
      ns = exp_src(mute, force_thru, pll_locked, unlock_mute);
      nrep = !stb_now;
      if (stb_now) begin
        left_in  = (f == 1) ? 28'hFFFFFFF : 28'($urandom);
        right_in = (f == 1) ? 28'h0000001 : 28'($urandom);
        hl = left_in; hr = right_in;
        frame_stb = 1'b1;
      end
      for (int c = 0; c < 128; c++) begin
        if (c == 1) frame_stb = 1'b0;
        slot = (c >= 64);
        e = exp_nrz(cf, slot ? cr : cl, (c % 64) / 2);
        chk("R2", bclk, 1'(c % 2), f, c);
        chk("R2", wclk, (cf == 3'd1 || cf == 3'd6) ? slot : ~slot, f, c);
        if (f == 0) tag = "R1";
        else if (cs != 0) tag = "R8";
        else if (rep) tag = "R9";
        else tag = fmt_tag(cf);
        chk(tag, sdata, (cs == 2) ? 1'b0 : (cs == 1) ? thru_in : (cf == 3'd5) ? bp : e, f, c);
        if (c % 2 == 1) bp = ~bp;
        else if (cf == 3'd5 && e) bp = ~bp;
        thru_in = $urandom % 2;
        @(negedge clk);
      end
      cl = hl; cr = hr; cf = nf; cs = ns; rep = nrep;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule